// File: doc/BRIEF.md
# Twisting Routing Switchbox

This block is a behavioural model of one routing switchbox in an island-style programmable fabric. Each of its four sides (left, top, right, bottom) has a W-bit input vector and a W-bit output vector. Every output track is driven by one track of one other side, or is held at 0. Which side feeds each output track comes from a configuration word, loaded bit by bit through a serial shift chain. Chains of neighbouring switchboxes can be cascaded through the serial output.

The track that an output connects to on the source side is fixed at elaboration by the `MODE` parameter. In mode 0 every connection keeps its track index. In mode 1 the two turns top/right and bottom/left reverse the bus (track i meets track W-1-i), and all other connections keep the index. In mode 2 the straight connections left/right and top/bottom also reverse. A multi-rail signal sent along such an arc leaves in reversed order, so a route with reversing hops yields a twisted bundle. The datapath from inputs to outputs holds no register.

Top module: `twist_switchbox`

## Requirements
- R1: Side codes are 0 = left, 1 = top, 2 = right, 3 = bottom. Output track j of side o is set by the three chain bits at base b = (o*W + j)*3: bits b+1..b hold the source side code, and bit b+2 is the enable.
- R2: With MODE = 0, an enabled output track j on side o that selects side s != o carries input track j of side s, for every pair of sides.
- R3: With MODE = 1, the top/right and bottom/left turns carry input track W-1-j. The left/top and right/bottom turns, and both straights, carry track j.
- R4: With MODE = 2, the straights left/right and top/bottom also carry input track W-1-j. The turns behave as in R3.
- R5: An output track whose enable bit is 0 drives 0, whatever its inputs are.
- R6: An output track whose source side code equals its own side drives 0, even when it is enabled.
- R7: On each rising edge of cfg_clk with cfg_en high, the chain shifts one place toward its top bit and cfg_sdi enters bit 0. A word loaded most-significant bit first sits in order after 4*W*3 shifts. cfg_sdo always shows the top chain bit.
- R8: While cfg_en is low, clock edges leave the configuration and cfg_sdo unchanged, whatever cfg_sdi does.
- R9: While cfg_rst_n is low, the whole configuration is cleared, so every output drives 0.
- R10: A W-bit bus sent twice along the same reversing arc comes back in its original order.
- R11: Outputs follow input changes combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_rst_n | input | 1 | Asynchronous active-low clear of the configuration |
| cfg_en | input | 1 | Shift enable for the chain |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_sdo | output | 1 | Top chain bit, for cascading |
| in_left | input | W | Left side input tracks |
| in_top | input | W | Top side input tracks |
| in_right | input | W | Right side input tracks |
| in_bottom | input | W | Bottom side input tracks |
| out_left | output | W | Left side output tracks |
| out_top | output | W | Top side output tracks |
| out_right | output | W | Right side output tracks |
| out_bottom | output | W | Bottom side output tracks |

## Verification
Routing results are combinational, so they are due in the same cycle as the input change. The bench changes inputs between clock edges and samples 1 ns later, with no edge in between. A configuration bit takes effect one cfg_clk edge after it is presented. The bench therefore drives cfg_sdi 1 ns after a rising edge and compares routing and cfg_sdo only after the last edge of a full load. It runs three instances, one per mode, and checks each against a bench model of the mapping.

// File: rtl/twist_switchbox.sv
module twist_switchbox #(
  parameter int W    = 8,
  parameter int MODE = 2
) (
  input  logic         cfg_clk,
  input  logic         cfg_rst_n,
  input  logic         cfg_en,
  input  logic         cfg_sdi,
  output logic         cfg_sdo,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_top,
  input  logic [W-1:0] in_right,
  input  logic [W-1:0] in_bottom,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_top,
  output logic [W-1:0] out_right,
  output logic [W-1:0] out_bottom
);
  localparam int  FIELD   = 3;
  localparam int  NBITS   = 4 * W * FIELD;
  localparam bit  REV_TURN = (MODE >= 1);
  localparam bit  REV_STR  = (MODE == 2);

  logic [NBITS-1:0]    chain;
  logic [3:0][W-1:0]   ins;
  logic [3:0][W-1:0]   outs;

  always_ff @(posedge cfg_clk or negedge cfg_rst_n)
    if (!cfg_rst_n)  chain <= '0;
    else if (cfg_en) chain <= {chain[NBITS-2:0], cfg_sdi};

  assign cfg_sdo = chain[NBITS-1];
  assign ins     = {in_bottom, in_right, in_top, in_left};

  for (genvar o = 0; o < 4; o++) begin : g_side
    for (genvar j = 0; j < W; j++) begin : g_trk
      localparam int B = (o * W + j) * FIELD;
      logic       en;
      logic [1:0] sel;
      logic [1:0] pair;
      logic       rev;
      assign en   = chain[B+2];
      assign sel  = chain[B +: 2];
      assign pair = 2'(o) ^ sel;
      assign rev  = (pair == 2'd3) ? REV_TURN :
                    (pair == 2'd2) ? REV_STR  : 1'b0;
      assign outs[o][j] = (en && sel != 2'(o)) ?
                          (rev ? ins[sel][W-1-j] : ins[sel][j]) : 1'b0;
    end
  end

  assign out_left   = outs[0];
  assign out_top    = outs[1];
  assign out_right  = outs[2];
  assign out_bottom = outs[3];
endmodule

// File: rtl/twist_switchbox_chk.sv
module twist_switchbox_chk #(
  parameter int W = 8
) (
  input logic                 cfg_clk,
  input logic                 cfg_rst_n,
  input logic                 cfg_en,
  input logic                 cfg_sdo,
  input logic [4*W*3-1:0]     chain,
  input logic [3:0][W-1:0]    outs
);
  localparam int NBITS = 4 * W * 3;

  a_r7_sdo_shift: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    cfg_en |=> cfg_sdo == $past(chain[NBITS-2]));

  a_r8_hold: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    !cfg_en |=> $stable(chain));

  a_r9_reset_zero: assert property (@(posedge cfg_clk)
    !cfg_rst_n |-> (outs == '0 && cfg_sdo == 1'b0));

  for (genvar o = 0; o < 4; o++) begin : g_o
    for (genvar j = 0; j < W; j++) begin : g_j
      a_r5_disabled_zero: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        !chain[(o*W+j)*3+2] |-> !outs[o][j]);
      a_r6_own_side_zero: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        (chain[(o*W+j)*3 +: 2] == 2'(o)) |-> !outs[o][j]);
    end
  end
endmodule

bind twist_switchbox twist_switchbox_chk #(.W(W)) u_chk (
  .cfg_clk   (cfg_clk),
  .cfg_rst_n (cfg_rst_n),
  .cfg_en    (cfg_en),
  .cfg_sdo   (cfg_sdo),
  .chain     (chain),
  .outs      (outs)
);

// File: tb/test_twist_switchbox.sv
module test_twist_switchbox;
  localparam int W  = 8;
  localparam int NB = 4 * W * 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic sdi = 1'b0;
  logic [3:0][W-1:0] ins;
  logic [3:0][W-1:0] o0, o1, o2;
  logic sdo0, sdo1, sdo2;

  logic       m_en  [4][W];
  logic [1:0] m_sel [4][W];

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  twist_switchbox #(.W(W), .MODE(0)) i_twist_switchbox_m0 (
    .cfg_clk(clk), .cfg_rst_n(rst_n), .cfg_en(en), .cfg_sdi(sdi), .cfg_sdo(sdo0),
    .in_left(ins[0]), .in_top(ins[1]), .in_right(ins[2]), .in_bottom(ins[3]),
    .out_left(o0[0]), .out_top(o0[1]), .out_right(o0[2]), .out_bottom(o0[3]));
  twist_switchbox #(.W(W), .MODE(1)) i_twist_switchbox_m1 (
    .cfg_clk(clk), .cfg_rst_n(rst_n), .cfg_en(en), .cfg_sdi(sdi), .cfg_sdo(sdo1),
    .in_left(ins[0]), .in_top(ins[1]), .in_right(ins[2]), .in_bottom(ins[3]),
    .out_left(o1[0]), .out_top(o1[1]), .out_right(o1[2]), .out_bottom(o1[3]));
  twist_switchbox #(.W(W), .MODE(2)) i_twist_switchbox (
    .cfg_clk(clk), .cfg_rst_n(rst_n), .cfg_en(en), .cfg_sdi(sdi), .cfg_sdo(sdo2),
    .in_left(ins[0]), .in_top(ins[1]), .in_right(ins[2]), .in_bottom(ins[3]),
    .out_left(o2[0]), .out_top(o2[1]), .out_right(o2[2]), .out_bottom(o2[3]));

  function automatic logic [3:0][W-1:0] got(int m);
    return (m == 0) ? o0 : (m == 1) ? o1 : o2;
  endfunction

  // R2 R3 R4 R5 R6: mapping model per mode
  function automatic logic [3:0][W-1:0] expect_out(int m);
    logic [3:0][W-1:0] r = '0;
    for (int o = 0; o < 4; o++)
      for (int j = 0; j < W; j++) begin
        int s = int'(m_sel[o][j]);
        bit turn_rev = ((o == 1 && s == 2) || (o == 2 && s == 1) ||
                        (o == 0 && s == 3) || (o == 3 && s == 0));
        bit str_rev  = ((o == 0 && s == 2) || (o == 2 && s == 0) ||
                        (o == 1 && s == 3) || (o == 3 && s == 1));
        bit rv = (turn_rev && m >= 1) || (str_rev && m == 2);
        if (m_en[o][j] && s != o) r[o][j] = rv ? ins[s][W-1-j] : ins[s][j];
      end
    return r;
  endfunction

  // R1: field layout of the chain
  function automatic logic [NB-1:0] pack_cfg();
    logic [NB-1:0] v = '0;
    for (int o = 0; o < 4; o++)
      for (int j = 0; j < W; j++) begin
        v[(o*W+j)*3 +: 2] = m_sel[o][j];
        v[(o*W+j)*3 + 2]  = m_en[o][j];
      end
    return v;
  endfunction

  task automatic check_all(string req);
    for (int m = 0; m < 3; m++) begin
      logic [3:0][W-1:0] a = got(m);
      logic [3:0][W-1:0] e = expect_out(m);
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s mode=%0d actual=%h expected=%h", req, m, a, e);
      end
    end
  endtask

  task automatic check_sdo(string req, logic e);
    checks++;
    if ({sdo0, sdo1, sdo2} !== {3{e}}) begin
      failures++;
      $display("FAIL %s sdo actual=%b%b%b expected=%b", req, sdo0, sdo1, sdo2, e);
    end
  endtask

  task automatic load_cfg();
    logic [NB-1:0] v = pack_cfg();
    for (int k = NB - 1; k >= 0; k--) begin
      sdi = v[k];
      en  = 1'b1;
      @(posedge clk);
      #1;
    end
    en = 1'b0;
  endtask

  task automatic rand_cfg(int pen);
    for (int o = 0; o < 4; o++)
      for (int j = 0; j < W; j++) begin
        m_en[o][j]  = ($urandom % 100) < pen;
        m_sel[o][j] = 2'($urandom % 4);
      end
  endtask

  task automatic clear_model();
    for (int o = 0; o < 4; o++)
      for (int j = 0; j < W; j++) begin
        m_en[o][j] = 1'b0; m_sel[o][j] = 2'd0;
      end
  endtask

  task automatic rand_ins();
    for (int s = 0; s < 4; s++) ins[s] = W'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NB-1:0] v;
    logic [W-1:0] x;
    logic [W-1:0] y [3];
    void'($urandom(32'h5eed_1234));
    clear_model();
    ins = '1;
    #3;
    check_all("R9 in reset");
    check_sdo("R9", 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    rand_ins();
    #1;
    check_all("R9 after reset");

    // R2 R3 R4 directed: every output of each side fed from one source side, all enabled
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 4; o++)
        for (int j = 0; j < W; j++) begin
          m_en[o][j] = 1'b1; m_sel[o][j] = 2'(s);
        end
      load_cfg();
      for (int p = 0; p < 3; p++) begin
        rand_ins();
        #1;
        check_all("R2 R3 R4 R6 single source");
      end
      ins = {4{W'(1)}};
      #1;
      check_all("R3 R4 walking one");
    end

    // R7: sdo shows first bit loaded, then next bit after one more shift
    rand_cfg(70);
    load_cfg();
    v = pack_cfg();
    check_sdo("R7 after load", v[NB-1]);
    rand_ins();
    #1;
    check_all("R1 R7 loaded order");

    // R8: enable low, sdi toggling, state kept
    for (int c = 0; c < 20; c++) begin
      sdi = 1'($urandom);
      @(posedge clk); #1;
    end
    check_all("R8 hold");
    check_sdo("R8 hold", v[NB-1]);

    sdi = ~v[NB-1];
    en = 1'b1;
    @(posedge clk); #1;
    en = 1'b0;
    check_sdo("R7 one shift", v[NB-2]);

    // R5 R2 R3 R4 random configurations
    for (int t = 0; t < 40; t++) begin
      rand_cfg(60);
      load_cfg();
      for (int p = 0; p < 4; p++) begin
        rand_ins();
        #1;
        check_all("R2 R3 R4 R5 R6 random");
      end
    end

    // R11: input change between edges shows without an edge
    @(posedge clk); #1;
    rand_ins();
    #0.5;
    check_all("R11 combinational");

    // R10: top fed from right twice, left fed from right (straight) twice
    clear_model();
    for (int j = 0; j < W; j++) begin
      m_en[1][j] = 1'b1; m_sel[1][j] = 2'd2;
      m_en[0][j] = 1'b1; m_sel[0][j] = 2'd2;
    end
    load_cfg();
    for (int arc = 0; arc < 2; arc++) begin
      x = W'($urandom) | W'(1);
      ins = '0;
      ins[2] = x;
      #1;
      for (int m = 0; m < 3; m++) y[m] = got(m)[arc == 0 ? 1 : 0];
      for (int m = 0; m < 3; m++) begin
        ins[2] = y[m];
        #1;
        checks++;
        if (got(m)[arc == 0 ? 1 : 0] !== x) begin
          failures++;
          $display("FAIL R10 arc=%0d mode=%0d actual=%h expected=%h",
                   arc, m, got(m)[arc == 0 ? 1 : 0], x);
        end
      end
      ins[2] = x;
      #1;
      check_all("R10 first pass");
    end

    // R9: reset in mid-run clears loaded routing
    rand_cfg(100);
    load_cfg();
    rst_n = 1'b0;
    #1;
    clear_model();
    rand_ins();
    #1;
    check_all("R9 mid-run reset");
    check_sdo("R9 mid-run", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule